// File: doc/BRIEF.md
# Power-Fail Access Gate and Reset Sequencer

This block sits between a byte-wide memory bus and a battery-backed storage array (RAM plus clock registers). It takes two digital supply-status flags from external comparators: one that is high while the supply is above the write-protect threshold, and one that is high while the supply is above the battery switchover point. Both flags pass through a synchronizer before any logic uses them.

While the supply is out of tolerance, the gate blocks every read and every write, whatever the strobes are doing. A write that is in flight when power fails is cancelled and never committed. The block drives an active-low system reset while power is bad. After power returns, it keeps that reset asserted for a programmable recovery interval. It also reports when the array runs from the battery.

A sticky backup-enable latch keeps the battery disconnected from reset until good power is seen for the first time. After that the latch stays set, so the backup path remains armed through all later outages.

Top module: `pg_gate_top`

## Requirements
- R1: While the synchronized write-protect flag is low, `mem_rd_o` is 0 and `rdata_o` is all zeros, even when `sel_ni`=0, `oe_ni`=0 and `we_ni`=1.
- R2: Two clock edges after `vok_wp_i` falls, `por_no` is 0. It stays 0 as long as the flag stays low.
- R3: `por_no` rises exactly REC_CYCLES+2 clock edges after `vok_wp_i` returns high. Any drop of the flag before that moment restarts the interval.
- R4: `bkup_en_o` is 0 from reset until the write-protect flag is first seen high. It becomes 1 three edges after that rise and then stays 1 through later power losses.
- R5: `on_batt_o` equals the inverse of the synchronized switchover flag, so it changes two edges after `vok_so_i` changes. `batt_sel_o` is `on_batt_o` AND `bkup_en_o`.
- R6: A write is the interval during which `sel_ni`=0 and `we_ni`=0. When the strobe is released, `mem_commit_o` is 1 for exactly one cycle, on the edge that samples the release. At the same time `mem_waddr_o` and `mem_wdata_o` carry the address and data from the last strobed cycle.
- R7: With good power, a read (`sel_ni`=0, `oe_ni`=0, `we_ni`=1) sets `mem_rd_o` to 1 in the same cycle and passes `rdata_i` to `rdata_o`.
- R8: A write with any sampled cycle of bad power during its strobe, or at its release, produces no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (first-time power state) |
| vok_wp_i | input | 1 | Supply above write-protect threshold (asynchronous) |
| vok_so_i | input | 1 | Supply above battery switchover point (asynchronous) |
| sel_ni | input | 1 | Bus chip select, active low |
| oe_ni | input | 1 | Bus output enable, active low |
| we_ni | input | 1 | Bus write strobe, active low |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | DATA_W | Bus write data |
| rdata_i | input | DATA_W | Read data from the storage array |
| mem_rd_o | output | 1 | Gated read enable to the array |
| rdata_o | output | DATA_W | Gated read data back to the bus |
| mem_commit_o | output | 1 | One-cycle write commit pulse to the array |
| mem_waddr_o | output | ADDR_W | Address of the committed write |
| mem_wdata_o | output | DATA_W | Data of the committed write |
| por_no | output | 1 | Active-low system reset |
| on_batt_o | output | 1 | Supply below switchover point |
| batt_sel_o | output | 1 | Battery actually selected as array supply |
| bkup_en_o | output | 1 | Backup source has been armed |

## Verification
Each flag change reaches the logic after two edges, so each result has its own due time. The read gate and the reset fall are due two edges after the change. The switchover indication is also due at two edges. The backup latch is due at three edges. The reset release is due at REC_CYCLES+2 edges, and a commit pulse is due one edge after the strobe release. When the bench applies a stimulus, it records each expected value together with the exact cycle at which it is due. The monitor compares only at that cycle, half a period after the edge. Checks one cycle before and one cycle after each due point confirm the timing is exact.

// File: rtl/pg_pkg.sv
package pg_pkg;
   // Two flops are the minimum for metastability settling on a flag.
   localparam int unsigned MIN_SYNC = 2;

   // Write cycle tracker states
   typedef enum logic [1:0] {
      WT_IDLE  = 2'd0,
      WT_CLEAN = 2'd1,
      WT_SPOIL = 2'd2
   } wr_state_t;

   // Counter width needed to hold 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[g] <= '0;
            else         stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg[g] <= '0;
            else         stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pg_recovery.sv
module pg_recovery #(
   parameter int unsigned REC_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic good_i,
   output logic por_no,
   output logic bkup_en_o
);
   logic por_q;
   logic bkup_q;

   if (REC_CYCLES == 1) begin : g_short
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) por_q <= 1'b0;
         else         por_q <= good_i;
      end
   end else begin : g_count
      localparam int unsigned CW = pg_pkg::cnt_width(REC_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
            por_q <= 1'b0;
         end else if (!good_i) begin
            cnt_q <= '0;
            por_q <= 1'b0;
         end else if (!por_q) begin
            if (cnt_q == LAST) por_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // Sticky: set by the first good supply, cleared only by rst_ni.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bkup_q <= 1'b0;
      else         bkup_q <= bkup_q | good_i;
   end

   // Reset drops in the same cycle the synchronized flag drops.
   assign por_no    = por_q & good_i;
   assign bkup_en_o = bkup_q;
endmodule

// File: rtl/pg_bus_gate.sv
module pg_bus_gate #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              good_i,
   input  logic              sel_ni,
   input  logic              oe_ni,
   input  logic              we_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              mem_rd_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              commit_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o
);
   import pg_pkg::*;

   wr_state_t         st_q, st_d;
   logic              wr_strobe;
   logic              commit_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   assign wr_strobe = ~sel_ni & ~we_ni;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         WT_IDLE:  if (wr_strobe) st_d = good_i ? WT_CLEAN : WT_SPOIL;
         WT_CLEAN: if (wr_strobe) st_d = good_i ? WT_CLEAN : WT_SPOIL;
                   else           st_d = WT_IDLE;
         WT_SPOIL: if (!wr_strobe) st_d = WT_IDLE;
         default:  st_d = WT_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= WT_IDLE;
         commit_q <= 1'b0;
         addr_q   <= '0;
         data_q   <= '0;
      end else begin
         st_q     <= st_d;
         commit_q <= (st_q == WT_CLEAN) & ~wr_strobe & good_i;
         if (wr_strobe && good_i) begin
            addr_q <= addr_i;
            data_q <= wdata_i;
         end
      end
   end

   assign mem_rd_o = good_i & ~sel_ni & ~oe_ni & we_ni;
   assign rdata_o  = mem_rd_o ? rdata_i : '0;
   assign commit_o = commit_q;
   assign waddr_o  = addr_q;
   assign wdata_o  = data_q;
endmodule

// File: rtl/pg_gate_top.sv
module pg_gate_top #(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REC_CYCLES  = 4375000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              vok_wp_i,
   input  logic              vok_so_i,
   input  logic              sel_ni,
   input  logic              oe_ni,
   input  logic              we_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              mem_rd_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mem_commit_o,
   output logic [ADDR_W-1:0] mem_waddr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              por_no,
   output logic              on_batt_o,
   output logic              batt_sel_o,
   output logic              bkup_en_o
);
   localparam int unsigned FLAG_W = 2;

   if (SYNC_STAGES < pg_pkg::MIN_SYNC) begin : g_chk_sync
      $error("pg_gate_top: SYNC_STAGES below minimum");
   end
   if (REC_CYCLES < 1) begin : g_chk_rec
      $error("pg_gate_top: REC_CYCLES must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_chk_width
      $error("pg_gate_top: bus widths must be non-zero");
   end

   logic [FLAG_W-1:0] flags_s;
   logic              pwr_good_s;
   logic              so_good_s;

   pg_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({vok_so_i, vok_wp_i}),
      .q_o    (flags_s)
   );

   assign pwr_good_s = flags_s[0];
   assign so_good_s  = flags_s[1];

   pg_recovery #(.REC_CYCLES(REC_CYCLES)) u_rec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .good_i    (pwr_good_s),
      .por_no    (por_no),
      .bkup_en_o (bkup_en_o)
   );

   pg_bus_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .good_i   (pwr_good_s),
      .sel_ni   (sel_ni),
      .oe_ni    (oe_ni),
      .we_ni    (we_ni),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .rdata_i  (rdata_i),
      .mem_rd_o (mem_rd_o),
      .rdata_o  (rdata_o),
      .commit_o (mem_commit_o),
      .waddr_o  (mem_waddr_o),
      .wdata_o  (mem_wdata_o)
   );

   assign on_batt_o  = ~so_good_s;
   assign batt_sel_o = on_batt_o & bkup_en_o;
endmodule

// File: rtl/pg_gate_chk.sv
module pg_gate_chk #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REC_CYCLES = 16
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              pwr_good_s,
   input logic              por_no,
   input logic              mem_rd_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              mem_commit_o,
   input logic              bkup_en_o,
   input logic              batt_sel_o
);
   localparam int unsigned RW = pg_pkg::cnt_width(REC_CYCLES);
   localparam logic [RW-1:0] FULL = RW'(REC_CYCLES);

   // Length of the current run of good power, saturating at the interval.
   logic [RW-1:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          run_q <= '0;
      else if (!pwr_good_s) run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
   end

   a_r1_no_read_when_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_good_s |-> (!mem_rd_o && rdata_o == '0));

   a_r3_full_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(por_no) |-> (run_q == FULL));

   a_r4_backup_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bkup_en_o |=> bkup_en_o);

   a_r5_batt_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      batt_sel_o |-> bkup_en_o);

   a_r6_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_commit_o |=> !mem_commit_o);
endmodule

bind pg_gate_top pg_gate_chk #(.DATA_W(DATA_W), .REC_CYCLES(REC_CYCLES)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .pwr_good_s   (pwr_good_s),
   .por_no       (por_no),
   .mem_rd_o     (mem_rd_o),
   .rdata_o      (rdata_o),
   .mem_commit_o (mem_commit_o),
   .bkup_en_o    (bkup_en_o),
   .batt_sel_o   (batt_sel_o)
);

// File: tb/pg_gate_top_tb_top.sv
module pg_gate_top_tb_top;
   localparam int AW  = 15;
   localparam int DW  = 8;
   localparam int REC = 20;

   localparam int S_POR = 0, S_MRD = 1, S_CMT = 2, S_BKUP = 3, S_BSEL = 4,
                  S_ONB = 5, S_RDATA = 6, S_WADDR = 7, S_WDATA = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vok_wp = 1'b0, vok_so = 1'b0;
   logic sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0, rdata_mem = '0;
   logic mem_rd, commit, por_n, on_batt, batt_sel, bkup_en;
   logic [DW-1:0] rdata, mwdata;
   logic [AW-1:0] mwaddr;

   always #4 clk = ~clk;

   pg_gate_top #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .REC_CYCLES(REC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .vok_wp_i(vok_wp), .vok_so_i(vok_so),
      .sel_ni(sel_n), .oe_ni(oe_n), .we_ni(we_n), .addr_i(addr), .wdata_i(wdata),
      .rdata_i(rdata_mem), .mem_rd_o(mem_rd), .rdata_o(rdata), .mem_commit_o(commit),
      .mem_waddr_o(mwaddr), .mem_wdata_o(mwdata), .por_no(por_n), .on_batt_o(on_batt),
      .batt_sel_o(batt_sel), .bkup_en_o(bkup_en));

   typedef struct {
      int    due;
      int    sig;
      int    val;
      string tag;
   } exp_t;

   exp_t sbq[$];
   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   function automatic int sample(input int s);
      case (s)
         S_POR:   return int'(por_n);
         S_MRD:   return int'(mem_rd);
         S_CMT:   return int'(commit);
         S_BKUP:  return int'(bkup_en);
         S_BSEL:  return int'(batt_sel);
         S_ONB:   return int'(on_batt);
         S_RDATA: return int'(rdata);
         S_WADDR: return int'(mwaddr);
         default: return int'(mwdata);
      endcase
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare every expectation that falls due this cycle.
   always @(negedge clk) begin
      for (int i = sbq.size() - 1; i >= 0; i--) begin
         if (sbq[i].due == cyc) begin
            n_chk++;
            if (sample(sbq[i].sig) != sbq[i].val) begin
               n_err++;
               $display("FAIL %s sig=%0d cyc=%0d actual=%0h expected=%0h",
                        sbq[i].tag, sbq[i].sig, cyc, sample(sbq[i].sig), sbq[i].val);
            end
            sbq.delete(i);
         end
      end
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic expect_in(input int d, input int s, input int v, input string tag);
      sbq.push_back('{cyc + d, s, v, tag});
   endtask

   // Advance to 1 ns after the n-th following falling edge.
   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int len, input bit ok, input string tag);
      sel_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
      expect_in(len, S_CMT, 0, tag);
      expect_in(len + 1, S_CMT, ok ? 1 : 0, tag);
      expect_in(len + 2, S_CMT, 0, tag);
      if (ok) begin
         expect_in(len + 1, S_WADDR, int'(a), tag);
         expect_in(len + 1, S_WDATA, int'(d), tag);
      end
      step(len);
      sel_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
      step(4);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      // Reset state: battery not armed, reset held, on battery but not selected (R4, R5, R2)
      expect_in(1, S_POR, 0, "R2");
      expect_in(1, S_BKUP, 0, "R4");
      expect_in(1, S_ONB, 1, "R5");
      expect_in(1, S_BSEL, 0, "R5");
      step(2);
      // Read before power is good is blocked (R1)
      sel_n = 1'b0; oe_n = 1'b0; rdata_mem = 8'hA5;
      expect_in(1, S_MRD, 0, "R1");
      expect_in(1, S_RDATA, 0, "R1");
      step(2);
      sel_n = 1'b1; oe_n = 1'b1;
      // Write while power is bad is dropped (R8)
      do_write(15'h0011, 8'h77, 3, 1'b0, "R8");
      // First power-up: timed release, backup latch arms (R3, R4, R5)
      vok_wp = 1'b1; vok_so = 1'b1;
      expect_in(REC + 1, S_POR, 0, "R3");
      expect_in(REC + 2, S_POR, 1, "R3");
      expect_in(2, S_BKUP, 0, "R4");
      expect_in(3, S_BKUP, 1, "R4");
      expect_in(1, S_ONB, 1, "R5");
      expect_in(2, S_ONB, 0, "R5");
      step(REC + 4);
      // Good write and read (R6, R7)
      do_write(15'h1234, 8'h3C, 2, 1'b1, "R6");
      do_write(15'h7FFE, 8'hC3, 1, 1'b1, "R6");
      sel_n = 1'b0; oe_n = 1'b0; rdata_mem = 8'h5A;
      expect_in(1, S_MRD, 1, "R7");
      expect_in(1, S_RDATA, 8'h5A, "R7");
      step(2);
      sel_n = 1'b1; oe_n = 1'b1;
      step(2);
      // Power fails in the middle of a write (R2, R8)
      sel_n = 1'b0; we_n = 1'b0; addr = 15'h0042; wdata = 8'hEE;
      step(2);
      vok_wp = 1'b0;
      expect_in(1, S_POR, 1, "R2");
      expect_in(2, S_POR, 0, "R2");
      step(4);
      sel_n = 1'b1; we_n = 1'b1;
      expect_in(1, S_CMT, 0, "R8");
      expect_in(2, S_CMT, 0, "R8");
      step(3);
      // Read while power is low; reset held; latch still armed (R1, R2, R4)
      sel_n = 1'b0; oe_n = 1'b0; rdata_mem = 8'hFF;
      expect_in(1, S_MRD, 0, "R1");
      expect_in(1, S_RDATA, 0, "R1");
      expect_in(1, S_POR, 0, "R2");
      expect_in(1, S_BKUP, 1, "R4");
      step(2);
      sel_n = 1'b1; oe_n = 1'b1;
      // Drop below switchover: battery selected (R5)
      vok_so = 1'b0;
      expect_in(1, S_ONB, 0, "R5");
      expect_in(2, S_ONB, 1, "R5");
      expect_in(2, S_BSEL, 1, "R5");
      step(5);
      vok_so = 1'b1;
      expect_in(2, S_BSEL, 0, "R5");
      step(3);
      // Short return then another drop restarts the interval (R3)
      vok_wp = 1'b1;
      expect_in(5, S_POR, 0, "R3");
      step(5);
      vok_wp = 1'b0;
      step(4);
      vok_wp = 1'b1;
      expect_in(REC + 1, S_POR, 0, "R3");
      expect_in(REC + 2, S_POR, 1, "R3");
      expect_in(REC + 2, S_BKUP, 1, "R4");
      step(REC + 4);
      // Write during good power after recovery (R6)
      do_write(15'h0AAA, 8'h81, 4, 1'b1, "R6");
      step(3);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule